// File: doc/BRIEF.md
# Single-Channel Analyzer Timing Logic

This block sits behind the analog front end of a pulse-height window analyzer. Three comparator levels arrive from the analog side. The first is the constant-fraction comparator, which is armed while a shaped pulse is rising and released as the pulse decays through half its peak. The second is the lower-level comparator and the third is the upper-level comparator. The block decides whether each pulse lands inside the energy window. If it does, the block emits an output pulse timed from the release of the constant-fraction comparator, not from a threshold crossing.

All three levels are first passed through two-flop synchronisers and then edge-detected. Rising edges of the lower-level and upper-level comparators are held in latches. The constant-fraction release makes a one-cycle qualify strobe, and the single-channel gate fires when three conditions hold together: the strobe is present, the lower-level latch is set, and the upper-level latch is not inhibiting the gate.

A gate firing starts a delay whose length is set by a cycle count. At the end of the delay, a positive pulse and its inverted twin are driven. Once the pulse is over, an internal reset clears both latches and strobes the peak-detector discharge.

Top module: `sca_timing`

## Requirements
- R1: After reset, `pos_out` is 0, `neg_out` is 1, and `dead_flag` and `discharge` are both 0.
- R2: The gate is evaluated only on a falling edge of `cf_in`. It fires only if the lower-level latch has been set since the last internal reset. A pulse that arms and releases `cf_in` without ever raising `ll_in` produces no output and no discharge strobe.
- R3: Once `ll_in` has risen, the lower-level latch stays set until the internal reset. A pulse whose `ll_in` falls before `cf_in` falls still fires.
- R4: The `mode` input is encoded as 2'b00 normal, 2'b01 window and 2'b10 integral. In normal, window and the spare code 2'b11, a set upper-level latch blocks the gate. In integral mode the upper-level latch never blocks the gate.
- R5: For a qualifying pulse, with D the value of `delay` when the gate fires, `pos_out` first goes high on rising edge D+4 after `cf_in` falls, where the edge count includes synchroniser, edge-detect and qualify stages. It then stays high for PULSE_W cycles (default 2).
- R6: `neg_out` is at all times the complement of `pos_out`, so the inverted pulse starts and ends on the same edges.
- R7: The internal reset fires when four conditions all hold: the lower-level latch is set, `ll_in` is low, `cf_in` is low, and the qualify strobe of the latest release has ended. `discharge` is then high for exactly one cycle. If `cf_in` falls first, `discharge` is high after rising edge 3 following the fall of `ll_in`. If `ll_in` falls first, it is high after rising edge 5 following the fall of `cf_in`.
- R8: The internal reset clears both latches. An upper-level event without a lower-level event causes no reset. In normal mode the set upper-level latch then blocks the next pulse that crosses the lower threshold, and the reset from that pulse clears it. In integral mode the same next pulse fires.
- R9: A gate firing while the delay or the output pulse is running is ignored and gives no extra output. `dead_flag` is high for one cycle, on the edge after the ignored gate. After the running pulse ends, a new pulse fires normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cf_in | input | 1 | Constant-fraction comparator level, asynchronous |
| ll_in | input | 1 | Lower-level comparator level, asynchronous |
| ul_in | input | 1 | Upper-level comparator level, asynchronous |
| mode | input | 2 | 00 normal, 01 window, 10 integral, 11 treated as differential |
| delay | input | DELAY_W | Output delay in clock cycles, sampled when the gate fires |
| pos_out | output | 1 | Positive output pulse |
| neg_out | output | 1 | Inverted output pulse |
| dead_flag | output | 1 | One-cycle flag for a gate dropped while busy |
| discharge | output | 1 | One-cycle peak-detector discharge strobe at internal reset |

## Verification
The assertions assume three things about the inputs. First, each comparator level holds for several cycles, so every synchronised edge is a clean single-cycle event. Second, `mode` stays constant from the start of a pulse until its internal reset. Third, within a pulse `ll_in` rises before `cf_in` falls, as happens with a real shaped pulse crossing the lower threshold on its way up.

The stimulus follows these assumptions. It changes comparator levels only on falling clock edges and at least two cycles apart. It sets `mode` and `delay` only between pulses, after the previous discharge strobe. It shapes every pulse as arm, lower crossing, optional upper crossing and release, with the order of the lower release and the constant-fraction release chosen per case.

// File: rtl/sca_pkg.sv
package sca_pkg;

  // Channel positions inside the synchronised comparator vector
  localparam int CH_CF = 0;
  localparam int CH_LL = 1;
  localparam int CH_UL = 2;
  localparam int N_CH  = 3;

  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'b00,
    MODE_WINDOW   = 2'b01,
    MODE_INTEGRAL = 2'b10,
    MODE_SPARE    = 2'b11
  } sca_mode_e;

  typedef enum logic [1:0] {
    OUT_IDLE  = 2'b00,
    OUT_WAIT  = 2'b01,
    OUT_PULSE = 2'b10
  } out_state_e;

  // Upper-level inhibit applies in every mode except integral
  function automatic logic ul_may_block(input logic [1:0] m);
    return m != MODE_INTEGRAL;
  endfunction

  function automatic logic rising(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic logic falling(input logic cur, input logic prev);
    return ~cur & prev;
  endfunction

  // Width needed to hold both a delay value and a pulse-width count
  function automatic int count_width(input int dw, input int pw);
    int pcw;
    pcw = $clog2(pw) + 1;
    return (dw > pcw) ? dw : pcw;
  endfunction

endpackage

// File: rtl/sca_sync.sv
module sca_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_d
);
  // STAGES synchroniser flops plus one history flop for edge detection
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[DEPTH-2:0], din};
  end

  assign lvl   = chain[STAGES-1];
  assign lvl_d = chain[STAGES];
endmodule

// File: rtl/sca_qualifier.sv
module sca_qualifier
  import sca_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic [N_CH-1:0] lvl,
  input  logic [N_CH-1:0] lvl_d,
  output logic            qual,
  output logic            gate,
  output logic            ll_lat,
  output logic            ul_lat,
  output logic            rst_evt,
  output logic            discharge
);
  logic cf_rise, cf_fall, ll_rise, ul_rise;
  logic cf_done;   // qualify strobe of the current pulse has come and gone
  logic ul_inhibit;

  assign cf_rise = rising (lvl[CH_CF], lvl_d[CH_CF]);
  assign cf_fall = falling(lvl[CH_CF], lvl_d[CH_CF]);
  assign ll_rise = rising (lvl[CH_LL], lvl_d[CH_LL]);
  assign ul_rise = rising (lvl[CH_UL], lvl_d[CH_UL]);

  // One-cycle qualify strobe just after the constant-fraction release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qual <= 1'b0;
    else        qual <= cf_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ll_lat <= 1'b0;
    else if (ll_rise) ll_lat <= 1'b1;
    else if (rst_evt) ll_lat <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ul_lat <= 1'b0;
    else if (ul_rise) ul_lat <= 1'b1;
    else if (rst_evt) ul_lat <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cf_done <= 1'b0;
    else if (rst_evt || cf_rise) cf_done <= 1'b0;
    else if (qual)               cf_done <= 1'b1;
  end

  assign ul_inhibit = ul_lat & ul_may_block(mode);
  assign gate       = qual & ll_lat & ~ul_inhibit;

  // Both releases must have happened, in whichever order they came
  assign rst_evt = ll_lat & ~lvl[CH_LL] & ~lvl[CH_CF] & cf_done & ~qual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) discharge <= 1'b0;
    else        discharge <= rst_evt;
  end
endmodule

// File: rtl/sca_pulse_gen.sv
module sca_pulse_gen
  import sca_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate,
  input  logic [DW-1:0] delay,
  output logic          pos_out,
  output logic          neg_out,
  output logic          dead_flag,
  output logic          busy
);
  localparam int CW = count_width(DW, PW);
  localparam logic [CW-1:0] PW_LAST = CW'(PW - 1);
  localparam logic [CW-1:0] ONE     = CW'(1);

  out_state_e    state, nstate;
  logic [CW-1:0] cnt, ncnt;

  always_comb begin
    nstate = state;
    ncnt   = cnt;
    unique case (state)
      OUT_IDLE: begin
        if (gate) begin
          if (delay == '0) begin
            nstate = OUT_PULSE;
            ncnt   = PW_LAST;
          end else begin
            nstate = OUT_WAIT;
            ncnt   = CW'(delay) - ONE;
          end
        end
      end
      OUT_WAIT: begin
        if (cnt == '0) begin
          nstate = OUT_PULSE;
          ncnt   = PW_LAST;
        end else begin
          ncnt = cnt - ONE;
        end
      end
      OUT_PULSE: begin
        if (cnt == '0) nstate = OUT_IDLE;
        else           ncnt   = cnt - ONE;
      end
      default: begin
        nstate = OUT_IDLE;
        ncnt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= OUT_IDLE;
      cnt       <= '0;
      pos_out   <= 1'b0;
      neg_out   <= 1'b1;
      dead_flag <= 1'b0;
    end else begin
      state     <= nstate;
      cnt       <= ncnt;
      pos_out   <= (nstate == OUT_PULSE);
      neg_out   <= (nstate != OUT_PULSE);
      dead_flag <= gate & (state != OUT_IDLE);
    end
  end

  assign busy = (state != OUT_IDLE);
endmodule

// File: rtl/sca_timing.sv
module sca_timing
  import sca_pkg::*;
#(
  parameter int DELAY_W     = 8,
  parameter int PULSE_W     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cf_in,
  input  logic               ll_in,
  input  logic               ul_in,
  input  logic [1:0]         mode,
  input  logic [DELAY_W-1:0] delay,
  output logic               pos_out,
  output logic               neg_out,
  output logic               dead_flag,
  output logic               discharge
);
  logic [N_CH-1:0] raw_w, lvl_w, lvl_d_w;
  // Internal events, named for the bound checker
  logic qual_w, gate_w, ll_lat_w, ul_lat_w, rst_evt_w, busy_w;

  always_comb begin
    raw_w        = '0;
    raw_w[CH_CF] = cf_in;
    raw_w[CH_LL] = ll_in;
    raw_w[CH_UL] = ul_in;
  end

  sca_sync #(.W(N_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (raw_w),
    .lvl   (lvl_w),
    .lvl_d (lvl_d_w)
  );

  sca_qualifier u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .lvl       (lvl_w),
    .lvl_d     (lvl_d_w),
    .qual      (qual_w),
    .gate      (gate_w),
    .ll_lat    (ll_lat_w),
    .ul_lat    (ul_lat_w),
    .rst_evt   (rst_evt_w),
    .discharge (discharge)
  );

  sca_pulse_gen #(.DW(DELAY_W), .PW(PULSE_W)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate      (gate_w),
    .delay     (delay),
    .pos_out   (pos_out),
    .neg_out   (neg_out),
    .dead_flag (dead_flag),
    .busy      (busy_w)
  );
endmodule

// File: rtl/sca_timing_chk.sv
module sca_timing_chk
  import sca_pkg::*;
#(
  parameter int PW = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       pos_out,
  input logic       neg_out,
  input logic       dead_flag,
  input logic       discharge,
  input logic       qual,
  input logic       gate,
  input logic       ll_lat,
  input logic       ul_lat,
  input logic       rst_evt,
  input logic       busy
);
  int run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= 0;
    else if (pos_out) run_q <= run_q + 1;
    else              run_q <= 0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !pos_out && !dead_flag);

  assert_qual_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    qual |=> !qual);

  assert_ll_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_lat && !rst_evt) |=> ll_lat);

  assert_integral_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && ll_lat && mode == MODE_INTEGRAL) |-> gate);

  assert_ul_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ul_lat && mode != MODE_INTEGRAL) |-> !gate);

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pos_out) |-> run_q == PW);

  assert_complement_R6: assert property (@(posedge clk) disable iff (!rst_n)
    neg_out != pos_out);

  assert_discharge_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    discharge |=> !discharge);

  assert_latch_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    discharge |-> !ll_lat);

  assert_dead_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dead_flag |-> $past(busy));
endmodule

bind sca_timing sca_timing_chk #(.PW(PULSE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .pos_out   (pos_out),
  .neg_out   (neg_out),
  .dead_flag (dead_flag),
  .discharge (discharge),
  .qual      (qual_w),
  .gate      (gate_w),
  .ll_lat    (ll_lat_w),
  .ul_lat    (ul_lat_w),
  .rst_evt   (rst_evt_w),
  .busy      (busy_w)
);

// File: tb/sca_timing_test.sv
module sca_timing_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cf = 1'b0, ll = 1'b0, ul = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] delay = 8'd0;
  logic       pos, neg, dead, dis;

  int nchecks = 0, nerrs = 0;

  always #5 clk = ~clk;

  sca_timing uut (
    .clk(clk), .rst_n(rst_n), .cf_in(cf), .ll_in(ll), .ul_in(ul),
    .mode(mode), .delay(delay), .pos_out(pos), .neg_out(neg),
    .dead_flag(dead), .discharge(dis)
  );

  // Port monitor, sampling on falling edges
  int cyc = 0, rises = 0, rise_cyc = 0, run = 0, last_w = 0;
  int dis_n = 0, dis_cyc = 0, dead_n = 0, compl_bad = 0;
  logic pos_prev = 1'b0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    pos_prev <= pos;
    if (pos && !pos_prev) begin
      rises    <= rises + 1;
      rise_cyc <= cyc + 1;
    end
    if (pos) run <= run + 1;
    else if (run != 0) begin
      last_w <= run;
      run    <= 0;
    end
    if (dis) begin
      dis_n   <= dis_n + 1;
      dis_cyc <= cyc + 1;
    end
    if (dead) dead_n <= dead_n + 1;
    if (rst_n && (neg === pos)) compl_bad <= compl_bad + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nerrs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // One shaped pulse; returns cycle labels of the CF release and LL release
  task automatic run_pulse(input logic has_ll, input logic has_ul, input logic ll_first,
                           input int settle, output int m_cf, output int m_rel);
    step(1); cf = 1'b1;
    step(2); if (has_ll) ll = 1'b1;
    step(2); if (has_ul) ul = 1'b1;
    step(2); ul = 1'b0;
    if (ll_first) begin
      m_rel = cyc; ll = 1'b0;
      step(3);
      m_cf = cyc; cf = 1'b0;
      step(settle);
    end else begin
      m_cf = cyc; cf = 1'b0;
      step(8);
      m_rel = cyc; ll = 1'b0;
      step(settle);
    end
  endtask

  // {mode[13:12], delay[11:4], has_ll[3], has_ul[2], ll_first[1], fire[0]}
  localparam logic [13:0] VEC [9] = '{
    {2'b00, 8'd0,  1'b1, 1'b0, 1'b0, 1'b1},
    {2'b00, 8'd5,  1'b1, 1'b1, 1'b0, 1'b0},
    {2'b01, 8'd3,  1'b1, 1'b0, 1'b1, 1'b1},
    {2'b01, 8'd0,  1'b1, 1'b1, 1'b1, 1'b0},
    {2'b10, 8'd7,  1'b1, 1'b1, 1'b0, 1'b1},
    {2'b10, 8'd1,  1'b1, 1'b0, 1'b1, 1'b1},
    {2'b00, 8'd2,  1'b0, 1'b0, 1'b0, 1'b0},
    {2'b11, 8'd4,  1'b1, 1'b1, 1'b0, 1'b0},
    {2'b00, 8'd12, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchecks + 1, nerrs + 1);
    $finish;
  end

  initial begin
    int mcf, mrel, r0, d0, k0;
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1 reset state
    check("R1 pos_out", int'(pos), 0);
    check("R1 neg_out", int'(neg), 1);
    check("R1 dead_flag", int'(dead), 0);
    check("R1 discharge", int'(dis), 0);

    // Table walk: R2 R3 R4 R5 R7
    for (int i = 0; i < 9; i++) begin
      logic [13:0] v;
      v = VEC[i];
      mode = v[13:12];
      delay = v[11:4];
      r0 = rises; d0 = dis_n;
      run_pulse(v[3], v[2], v[1], 60, mcf, mrel);
      check(v[0] ? "R2 R3 output count" : "R2 R4 suppressed output", rises - r0, int'(v[0]));
      if (v[0]) begin
        check("R5 rise cycle", rise_cyc, mcf + int'(v[11:4]) + 4);
        check("R5 pulse width", last_w, 2);
      end
      if (v[3]) begin
        check("R7 discharge count", dis_n - d0, 1);
        check("R7 discharge cycle", dis_cyc, v[1] ? mcf + 5 : mrel + 3);
      end else begin
        check("R2 R7 no discharge without LL", dis_n - d0, 0);
      end
    end

    // R8: upper-only event in normal mode blocks the next LL pulse
    mode = 2'b00; delay = 8'd0;
    r0 = rises; d0 = dis_n;
    run_pulse(1'b0, 1'b1, 1'b0, 20, mcf, mrel);
    check("R8 upper-only no output", rises - r0, 0);
    check("R8 upper-only no reset", dis_n - d0, 0);
    r0 = rises; d0 = dis_n;
    run_pulse(1'b1, 1'b0, 1'b0, 20, mcf, mrel);
    check("R8 stale upper latch blocks", rises - r0, 0);
    check("R8 reset clears latches", dis_n - d0, 1);
    r0 = rises;
    run_pulse(1'b1, 1'b0, 1'b0, 20, mcf, mrel);
    check("R8 fires after clear", rises - r0, 1);

    // R8 R4: same sequence in integral mode fires at once
    mode = 2'b10;
    run_pulse(1'b0, 1'b1, 1'b0, 20, mcf, mrel);
    r0 = rises;
    run_pulse(1'b1, 1'b0, 1'b0, 20, mcf, mrel);
    check("R8 R4 integral ignores stale upper", rises - r0, 1);

    // R9: second gate inside a long delay is dropped
    mode = 2'b00; delay = 8'd30;
    r0 = rises; k0 = dead_n;
    run_pulse(1'b1, 1'b0, 1'b0, 4, mcf, mrel);
    d0 = mcf;
    run_pulse(1'b1, 1'b0, 1'b0, 60, mcf, mrel);
    check("R9 one output for two gates", rises - r0, 1);
    check("R9 dead_flag pulses", dead_n - k0, 1);
    check("R9 first pulse timing kept", rise_cyc, d0 + 34);
    delay = 8'd0;
    r0 = rises; k0 = dead_n;
    run_pulse(1'b1, 1'b0, 1'b1, 20, mcf, mrel);
    check("R9 recovers after busy", rises - r0, 1);
    check("R9 no dead when idle", dead_n - k0, 0);

    // R6 complement held throughout
    check("R6 neg_out complement", compl_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end
endmodule